// File: doc/BRIEF.md
# Serial Programming Link Sequencer

This block runs the control scripts that a host needs to open and use a single-wire serial programming link to a small target device. It sits above a frame engine, which does the bit-level framing. The sequencer gives that engine one command at a time: idle-clock, transmit byte or receive byte. It also drives the target's reset line directly.

Three operations are selected by `op_i` and launched by `start_i`:
- **Link bring-up** produces the reset waveform, clocks an idle preamble, shortens the guard time and checks the identification byte.
- **Programming enable** sends the key opcode and the 64-bit key, then checks the memory-enable status bit.
- **Whole-memory erase** waits for the busy flag to clear, loads the erase command, sets the 16-bit pointer, issues a dummy store and waits again.

Each operation ends with a one-cycle `done_o` pulse and a pass/fail result on `pass_o`.

Each command follows a handshake. The sequencer holds `cmd_valid_o` together with `cmd_kind_o` and `cmd_data_o` until `cmd_ready_i`, then waits for `rsp_valid_i`. An error flag on the response aborts the running operation with a failure. Opcodes, register addresses, the erase command, the base address, the reset phase lengths and the poll limit are all parameters.

Top module: `prog_link_seq`

## Requirements
- R1: After reset, `done_o`, `pass_o`, `cmd_valid_o` and `rst_tgt_o` are all 0.
- R2: Bring-up drives `rst_tgt_o` high for T_HI cycles, then low for T_LO cycles, then high for T_PULSE cycles, then leaves it low. No command is issued before this waveform completes.
- R3: After the reset waveform, bring-up issues these commands in order. Kind codes are 0 = idle clocks, 1 = transmit, 2 = receive; receive commands carry data 0x00.
  - idle with data 16
  - transmit 0xC2 (control store to register 2)
  - transmit 0x07
  - transmit 0x8F (control load of register 15)
  - receive
- R4: Bring-up passes only when the received identification byte equals 0x80.
- R5: Enable issues these commands in order, and passes only when bit 1 of the received byte is 1:
  - transmit 0xE0
  - the eight key bytes, from `key_i[63:56]` down to `key_i[7:0]`
  - transmit 0x80
  - receive
- R6: Erase issues a busy poll, then these transmits in order, then a second busy poll:
  - 0xF3 (I/O out to address 0x33)
  - 0x10
  - 0x68
  - base low byte OR 0x01 (0x01 for base 0x4000)
  - 0x69
  - base high byte (0x40)
  - 0x60
  - 0xFF
- R7: A busy poll consists of transmit 0x72 (I/O in from address 0x32) followed by receive. The pair repeats while bit 7 of the received byte is 1. After MAX_POLLS (4) consecutive busy reads, the operation fails.
- R8: A response with `rsp_err_i` = 1 ends the operation on the next cycle with `done_o` = 1 and `pass_o` = 0. No further command is issued.
- R9: `done_o` is a single-cycle pulse once per operation. `pass_o` holds the result until the next accepted start.
- R10: `start_i` is ignored while an operation is running: the command stream and the done count are unaffected.
- R11: An `op_i` value of 3 completes with `pass_o` = 0 and issues no command.
- R12: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, `cmd_valid_o`, `cmd_kind_o` and `cmd_data_o` hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch the selected operation |
| op_i | input | 2 | 0 bring-up, 1 enable, 2 erase |
| key_i | input | 64 | Programming key, byte 7 sent first |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last operation |
| rst_tgt_o | output | 1 | Target reset line |
| cmd_valid_o | output | 1 | Command request to frame engine |
| cmd_kind_o | output | 2 | 0 idle clocks, 1 transmit, 2 receive |
| cmd_data_o | output | 8 | Transmit byte or idle clock count |
| cmd_ready_i | input | 1 | Frame engine accepts command |
| rsp_valid_i | input | 1 | Command finished |
| rsp_data_i | input | 8 | Received byte |
| rsp_err_i | input | 1 | Frame error on this command |

## Verification
A command appears on `cmd_valid_o` in the cycle after the previous response is consumed (or after the reset waveform ends). It then holds until accepted. `done_o` rises one cycle after the deciding response, or one cycle after the final script step. The bench's engine model answers each request one cycle after acceptance and compares every command as it appears. The bench samples all outputs on falling edges, waits for `done_o` with a bound, and then checks that it drops on the following falling edge. The reset waveform is checked by counting the sampled high and low run lengths of `rst_tgt_o` against the three phase parameters.

// File: rtl/pls_pkg.sv
package pls_pkg;
  typedef enum logic [1:0] {KIND_IDLE = 2'd0, KIND_TX = 2'd1, KIND_RX = 2'd2} kind_e;
  typedef enum logic [1:0] {ACT_CMD, ACT_RST, ACT_OK, ACT_FAIL} act_e;
  typedef enum logic [1:0] {CHK_NONE, CHK_EQ, CHK_BIT, CHK_POLL} chk_e;

  typedef struct packed {
    act_e       act;
    kind_e      kind;
    logic [7:0] data;
    chk_e       chk;
    logic [7:0] ref_v;
  } step_t;

  localparam int STEP_W = 4;

  // I/O-space opcode: address bits 5:4 land in opcode bits 6:5
  function automatic logic [7:0] io_opcode(input logic [7:0] base, input logic [5:0] addr);
    return base | {1'b0, addr[5:4], 1'b0, addr[3:0]};
  endfunction
endpackage

// File: rtl/pls_script.sv
module pls_script import pls_pkg::*; #(
  parameter logic [7:0]  OPC_LDCS   = 8'h80,
  parameter logic [7:0]  OPC_STCS   = 8'hC0,
  parameter logic [7:0]  OPC_KEY    = 8'hE0,
  parameter logic [7:0]  OPC_IN     = 8'h10,
  parameter logic [7:0]  OPC_OUT    = 8'h90,
  parameter logic [7:0]  OPC_STPR   = 8'h68,
  parameter logic [7:0]  OPC_ST     = 8'h60,
  parameter logic [3:0]  REG_PHY    = 4'h2,
  parameter logic [3:0]  REG_IDENT  = 4'hF,
  parameter logic [3:0]  REG_STAT   = 4'h0,
  parameter logic [5:0]  IO_CMD     = 6'h33,
  parameter logic [5:0]  IO_CSR     = 6'h32,
  parameter logic [7:0]  ERASE_CMD  = 8'h10,
  parameter logic [15:0] BASE_ADDR  = 16'h4000,
  parameter logic [7:0]  GUARD_VAL  = 8'h07,
  parameter logic [7:0]  IDENT_VAL  = 8'h80,
  parameter int          EN_BIT     = 1,
  parameter int          BUSY_BIT   = 7,
  parameter int          PREAMBLE   = 16
) (
  input  logic [1:0]        op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [63:0]       key_i,
  output step_t             ent_o
);
  function automatic step_t tx(input logic [7:0] d);
    return '{ACT_CMD, KIND_TX, d, CHK_NONE, 8'h00};
  endfunction
  function automatic step_t rx(input chk_e c, input logic [7:0] r);
    return '{ACT_CMD, KIND_RX, 8'h00, c, r};
  endfunction

  localparam step_t END_OK   = '{ACT_OK,   KIND_IDLE, 8'h00, CHK_NONE, 8'h00};
  localparam step_t END_FAIL = '{ACT_FAIL, KIND_IDLE, 8'h00, CHK_NONE, 8'h00};
  localparam logic [7:0] POLL_OP = io_opcode(OPC_IN, IO_CSR);

  always_comb begin
    ent_o = END_FAIL;
    unique case (op_i)
      2'd0: begin
        case (step_i)
          4'd0: ent_o = '{ACT_RST, KIND_IDLE, 8'h00, CHK_NONE, 8'h00};
          4'd1: ent_o = '{ACT_CMD, KIND_IDLE, 8'(PREAMBLE), CHK_NONE, 8'h00};
          4'd2: ent_o = tx(OPC_STCS | {4'h0, REG_PHY});
          4'd3: ent_o = tx(GUARD_VAL);
          4'd4: ent_o = tx(OPC_LDCS | {4'h0, REG_IDENT});
          4'd5: ent_o = rx(CHK_EQ, IDENT_VAL);
          default: ent_o = END_OK;
        endcase
      end
      2'd1: begin
        if (step_i == 4'd0) ent_o = tx(OPC_KEY);
        else if (step_i == 4'd9) ent_o = tx(OPC_LDCS | {4'h0, REG_STAT});
        else if (step_i == 4'd10) ent_o = rx(CHK_BIT, 8'(EN_BIT));
        else ent_o = END_OK;
        for (int k = 0; k < 8; k++) begin
          // highest-indexed key byte goes first
          if (step_i == STEP_W'(k + 1)) ent_o = tx(key_i[8*(7-k) +: 8]);
        end
      end
      2'd2: begin
        case (step_i)
          4'd0, 4'd10: ent_o = tx(POLL_OP);
          4'd1, 4'd11: ent_o = rx(CHK_POLL, 8'(BUSY_BIT));
          4'd2: ent_o = tx(io_opcode(OPC_OUT, IO_CMD));
          4'd3: ent_o = tx(ERASE_CMD);
          4'd4: ent_o = tx(OPC_STPR);
          4'd5: ent_o = tx(BASE_ADDR[7:0] | 8'h01);
          4'd6: ent_o = tx(OPC_STPR | 8'h01);
          4'd7: ent_o = tx(BASE_ADDR[15:8]);
          4'd8: ent_o = tx(OPC_ST);
          4'd9: ent_o = tx(8'hFF);
          default: ent_o = END_OK;
        endcase
      end
      default: ent_o = END_FAIL;
    endcase
  end
endmodule

// File: rtl/pls_rst_gen.sv
module pls_rst_gen #(
  parameter int T_HI    = 1000,
  parameter int T_LO    = 2000,
  parameter int T_PULSE = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic rst_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXT = (T_HI > T_LO) ? ((T_HI > T_PULSE) ? T_HI : T_PULSE)
                                      : ((T_LO > T_PULSE) ? T_LO : T_PULSE);
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_HI, PH_LO, PH_PUL} ph_e;
  ph_e ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      rst_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q  <= PH_HI;
          cnt_q <= CW'(T_HI - 1);
          rst_o <= 1'b1;
        end
        PH_HI: if (cnt_q == '0) begin
          ph_q  <= PH_LO;
          cnt_q <= CW'(T_LO - 1);
          rst_o <= 1'b0;
        end else cnt_q <= cnt_q - 1'b1;
        PH_LO: if (cnt_q == '0) begin
          ph_q  <= PH_PUL;
          cnt_q <= CW'(T_PULSE - 1);
          rst_o <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        PH_PUL: if (cnt_q == '0) begin
          ph_q   <= PH_IDLE;
          rst_o  <= 1'b0;
          done_o <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);

  // R2
  go_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_o);
endmodule

// File: rtl/pls_poll.sv
module pls_poll #(
  parameter int MAX_POLLS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));

  // R7
  poll_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/prog_link_seq.sv
module prog_link_seq import pls_pkg::*; #(
  parameter logic [7:0]  OPC_LDCS   = 8'h80,
  parameter logic [7:0]  OPC_STCS   = 8'hC0,
  parameter logic [7:0]  OPC_KEY    = 8'hE0,
  parameter logic [7:0]  OPC_IN     = 8'h10,
  parameter logic [7:0]  OPC_OUT    = 8'h90,
  parameter logic [7:0]  OPC_STPR   = 8'h68,
  parameter logic [7:0]  OPC_ST     = 8'h60,
  parameter logic [3:0]  REG_PHY    = 4'h2,
  parameter logic [3:0]  REG_IDENT  = 4'hF,
  parameter logic [3:0]  REG_STAT   = 4'h0,
  parameter logic [5:0]  IO_CMD     = 6'h33,
  parameter logic [5:0]  IO_CSR     = 6'h32,
  parameter logic [7:0]  ERASE_CMD  = 8'h10,
  parameter logic [15:0] BASE_ADDR  = 16'h4000,
  parameter logic [7:0]  GUARD_VAL  = 8'h07,
  parameter logic [7:0]  IDENT_VAL  = 8'h80,
  parameter int          EN_BIT     = 1,
  parameter int          BUSY_BIT   = 7,
  parameter int          PREAMBLE   = 16,
  parameter int          T_HI       = 1000,
  parameter int          T_LO       = 2000,
  parameter int          T_PULSE    = 50,
  parameter int          MAX_POLLS  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [63:0] key_i,
  output logic        done_o,
  output logic        pass_o,
  output logic        rst_tgt_o,
  output logic        cmd_valid_o,
  output logic [1:0]  cmd_kind_o,
  output logic [7:0]  cmd_data_o,
  input  logic        cmd_ready_i,
  input  logic        rsp_valid_i,
  input  logic [7:0]  rsp_data_i,
  input  logic        rsp_err_i
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_RST, S_WAIT} st_e;

  st_e               st_q;
  logic [1:0]        op_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q, pass_q;
  step_t             ent;
  logic              rst_go, rst_busy, rst_done;
  logic              poll_inc, poll_clr, poll_last;
  logic              rsp_take, chk_ok, busy_seen;

  pls_script #(
    .OPC_LDCS(OPC_LDCS), .OPC_STCS(OPC_STCS), .OPC_KEY(OPC_KEY), .OPC_IN(OPC_IN),
    .OPC_OUT(OPC_OUT), .OPC_STPR(OPC_STPR), .OPC_ST(OPC_ST), .REG_PHY(REG_PHY),
    .REG_IDENT(REG_IDENT), .REG_STAT(REG_STAT), .IO_CMD(IO_CMD), .IO_CSR(IO_CSR),
    .ERASE_CMD(ERASE_CMD), .BASE_ADDR(BASE_ADDR), .GUARD_VAL(GUARD_VAL),
    .IDENT_VAL(IDENT_VAL), .EN_BIT(EN_BIT), .BUSY_BIT(BUSY_BIT), .PREAMBLE(PREAMBLE)
  ) script_i (
    .op_i(op_q), .step_i(step_q), .key_i(key_i), .ent_o(ent)
  );

  pls_rst_gen #(.T_HI(T_HI), .T_LO(T_LO), .T_PULSE(T_PULSE)) rst_gen_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(rst_go),
    .rst_o(rst_tgt_o), .busy_o(rst_busy), .done_o(rst_done)
  );

  pls_poll #(.MAX_POLLS(MAX_POLLS)) poll_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(poll_clr), .inc_i(poll_inc), .last_o(poll_last)
  );

  assign rsp_take  = (st_q == S_WAIT) && rsp_valid_i && !rsp_err_i;
  assign busy_seen = rsp_data_i[ent.ref_v[2:0]];

  always_comb begin
    unique case (ent.chk)
      CHK_EQ:  chk_ok = (rsp_data_i == ent.ref_v);
      CHK_BIT: chk_ok = rsp_data_i[ent.ref_v[2:0]];
      default: chk_ok = 1'b1;
    endcase
  end

  assign rst_go      = (st_q == S_RUN) && (ent.act == ACT_RST);
  assign poll_inc    = rsp_take && (ent.chk == CHK_POLL) && busy_seen && !poll_last;
  assign poll_clr    = (st_q == S_IDLE) || (rsp_take && (ent.chk == CHK_POLL) && !busy_seen);
  assign cmd_valid_o = (st_q == S_RUN) && (ent.act == ACT_CMD);
  assign cmd_kind_o  = ent.kind;
  assign cmd_data_o  = ent.data;
  assign done_o      = done_q;
  assign pass_o      = pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          op_q   <= op_i;
          step_q <= '0;
          pass_q <= 1'b0;
          st_q   <= S_RUN;
        end
        S_RUN: begin
          unique case (ent.act)
            ACT_OK:   begin done_q <= 1'b1; pass_q <= 1'b1; st_q <= S_IDLE; end
            ACT_FAIL: begin done_q <= 1'b1; pass_q <= 1'b0; st_q <= S_IDLE; end
            ACT_RST:  st_q <= S_RST;
            default:  if (cmd_ready_i) st_q <= S_WAIT;
          endcase
        end
        S_RST: if (rst_done) begin
          step_q <= step_q + 1'b1;
          st_q   <= S_RUN;
        end
        S_WAIT: if (rsp_valid_i) begin
          if (rsp_err_i) begin
            done_q <= 1'b1; pass_q <= 1'b0; st_q <= S_IDLE;
          end else if (ent.chk == CHK_POLL && busy_seen) begin
            if (poll_last) begin
              done_q <= 1'b1; pass_q <= 1'b0; st_q <= S_IDLE;
            end else begin
              step_q <= step_q - 1'b1;  // re-issue the status read
              st_q   <= S_RUN;
            end
          end else if (!chk_ok) begin
            done_q <= 1'b1; pass_q <= 1'b0; st_q <= S_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= S_RUN;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R12
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_kind_o) && $stable(cmd_data_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  err_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == S_WAIT) && rsp_valid_i && rsp_err_i) |=> (done_o && !pass_o && !cmd_valid_o));

  // R2
  no_cmd_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy |-> !cmd_valid_o);

  // R9
  pass_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && (st_q != S_IDLE || !start_i) && $past(st_q) != S_IDLE) |-> $stable(pass_o));
endmodule

// File: tb/prog_link_seq_tb_top.sv
module prog_link_seq_tb_top;
  localparam int T_HI = 5, T_LO = 3, T_PULSE = 2, MAX_POLLS = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [63:0] key = 64'h0123_4567_89AB_CDEF;
  logic cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic done, pass, rst_tgt, cmd_valid;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_data;

  int checks = 0, errors = 0, cmd_num = 0, err_at = -1, poke_at = -1, done_cnt = 0;
  logic [9:0] exp_q[$];
  logic [7:0] rx_q[$];
  string cur_req = "R3";

  always #4 clk = ~clk;

  prog_link_seq #(.T_HI(T_HI), .T_LO(T_LO), .T_PULSE(T_PULSE), .MAX_POLLS(MAX_POLLS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .key_i(key),
    .done_o(done), .pass_o(pass), .rst_tgt_o(rst_tgt), .cmd_valid_o(cmd_valid),
    .cmd_kind_o(cmd_kind), .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_err_i(rsp_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_tx(input logic [7:0] d); exp_q.push_back({2'd1, d}); endtask
  task automatic push_rx(input logic [7:0] r); exp_q.push_back({2'd2, 8'h00}); rx_q.push_back(r); endtask
  task automatic push_poll(input logic [7:0] r); push_tx(8'h72); push_rx(r); endtask

  // engine model + scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (cmd_valid && rst_n) begin
      if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected command", {cmd_kind, cmd_data}, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({cmd_kind, cmd_data} == e, cur_req, "command", {cmd_kind, cmd_data}, e);
      end
      cmd_ready = 1'b1;
      if (cmd_num == poke_at) begin start = 1'b1; op = 2'd0; end
      @(negedge clk);
      cmd_ready = 1'b0;
      start = 1'b0;
      rsp_valid = 1'b1;
      rsp_err = (cmd_num == err_at);
      rsp_data = (cmd_kind == 2'd2 && rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
      cmd_num++;
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_err = 1'b0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
  end

  task automatic run_op(input logic [1:0] o, input bit exp_pass, input string req);
    int n;
    cur_req = req;
    @(negedge clk);
    op = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (o == 2'd0) begin
      int w;
      n = 0;
      while (!rst_tgt && n < 50) begin @(negedge clk); n++; end
      w = 0; while (rst_tgt && w < 100) begin @(negedge clk); w++; end
      chk(w == T_HI, "R2", "reset high width", w, T_HI);
      w = 0; while (!rst_tgt && w < 100) begin chk(!cmd_valid, "R2", "cmd during reset", 1, 0); @(negedge clk); w++; end
      chk(w == T_LO, "R2", "reset low width", w, T_LO);
      w = 0; while (rst_tgt && w < 100) begin @(negedge clk); w++; end
      chk(w == T_PULSE, "R2", "reset pulse width", w, T_PULSE);
    end
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk(done, req, "done seen", done, 1);
    chk(pass == exp_pass, req, "pass", pass, exp_pass);
    @(negedge clk);
    chk(!done, "R9", "done single pulse", done, 0);
    repeat (3) @(negedge clk);
    chk(pass == exp_pass, "R9", "pass held", pass, exp_pass);
    chk(exp_q.size() == 0, req, "commands left", exp_q.size(), 0);
    exp_q.delete(); rx_q.delete();
  endtask

  task automatic push_key(input logic [63:0] k);
    push_tx(8'hE0);
    for (int i = 7; i >= 0; i--) push_tx(k[8*i +: 8]);
  endtask

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1
    chk(!done && !pass && !cmd_valid && !rst_tgt, "R1", "reset outputs", {done, pass, cmd_valid, rst_tgt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !pass && !cmd_valid && !rst_tgt, "R1", "idle outputs", {done, pass, cmd_valid, rst_tgt}, 0);

    // R3 R4 bring-up pass
    exp_q.push_back({2'd0, 8'd16}); push_tx(8'hC2); push_tx(8'h07); push_tx(8'h8F); push_rx(8'h80);
    run_op(2'd0, 1'b1, "R4");
    chk(!rst_tgt, "R2", "reset left low", rst_tgt, 0);
    // R4 wrong ident
    exp_q.push_back({2'd0, 8'd16}); push_tx(8'hC2); push_tx(8'h07); push_tx(8'h8F); push_rx(8'h81);
    run_op(2'd0, 1'b0, "R4");

    // R5 enable pass / fail
    push_key(key); push_tx(8'h80); push_rx(8'h02);
    run_op(2'd1, 1'b1, "R5");
    key = 64'hFEDC_BA98_7654_3210;
    push_key(key); push_tx(8'h80); push_rx(8'hFD);
    run_op(2'd1, 1'b0, "R5");

    // R6 R7 erase with one busy read, R10 start poke mid-run
    d0 = done_cnt;
    poke_at = cmd_num + 3;
    push_poll(8'h80); push_poll(8'h00);
    push_tx(8'hF3); push_tx(8'h10); push_tx(8'h68); push_tx(8'h01);
    push_tx(8'h69); push_tx(8'h40); push_tx(8'h60); push_tx(8'hFF);
    push_poll(8'h00);
    run_op(2'd2, 1'b1, "R6");
    poke_at = -1;
    cur_req = "R10";
    repeat (20) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10", "done count", done_cnt, d0 + 1);
    chk(!rst_tgt, "R10", "no bring-up started", rst_tgt, 0);

    // R7 timeout
    for (int i = 0; i < MAX_POLLS; i++) push_poll(8'h80);
    run_op(2'd2, 1'b0, "R7");

    // R8 error on third command
    err_at = cmd_num + 2;
    push_tx(8'hE0); push_tx(key[63:56]); push_tx(key[55:48]);
    run_op(2'd1, 1'b0, "R8");
    err_at = -1;
    cur_req = "R8";
    repeat (10) @(negedge clk);

    // R11 invalid op
    run_op(2'd3, 1'b0, "R11");
    repeat (10) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule